// File: doc/BRIEF.md
# Low-Speed Independent Watchdog

This block is a watchdog that runs from its own slow clock, apart from the system bus clock. Software controls it through a small register bus. It writes 16-bit key codes to arm the counter, to feed it and to open or close write access to the divider and reload settings. Every bus write crosses into the slow clock domain through a handshake channel that loses no update. The bus side sees a busy flag for the divider setting and one for the reload setting while an update is still in flight.

Once armed, a power-of-two prescaler divides the slow clock. Each prescaler period decrements a 12-bit counter. If software does not feed the counter in time, the block raises a reset request that holds until the block's own reset. After arming, no bus write can stop the counter.

Top module: `lsw_watchdog`

## Requirements
- R1: After rst_n, wd_reset_req, pr_busy and rl_busy are low, the reload setting is 4095 and the divider code is 0 (divide by 4), so arming with no other write gives a timeout of 16380 slow-clock cycles.
- R2: Until key 0xCCCC is written at address 0, the counter stays idle and no reset request is raised, even after feed keys and setting writes.
- R3: After arming or feeding takes effect, wd_reset_req rises after divisor × max(reload,1) slow-clock cycles and stays high until rst_n.
- R4: The divider code is bits [2:0] at address 1. Codes 0 to 6 select a divide by 4 << code, and code 7 also selects divide by 256.
- R5: The reload value is bits [11:0] at address 2. A reload of 0 behaves like a reload of 1.
- R6: Key 0xAAAA at address 0 reloads the counter and restarts the prescaler phase, so regular feeding keeps wd_reset_req low.
- R7: Key 0x5555 opens write access to addresses 1 and 2, and any other key value closes it. A write to address 1 or 2 while closed is ignored and its busy flag stays low.
- R8: Once armed, no bus write stops or slows the expiry. Only rst_n returns the block to idle.
- R9: pr_busy (address 1) and rl_busy (address 2) are high at the first bus-clock sample after an accepted write, and low again within a few slow-clock cycles once the value is applied.
- R10: Back-to-back writes are never lost. The last written setting is applied, and a key event that arrives while an earlier one is crossing still takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bus_clk | input | 1 | Register bus clock |
| wd_clk | input | 1 | Independent low-speed watchdog clock |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| bus_wr | input | 1 | Write strobe, one bus-clock cycle per write |
| bus_addr | input | 2 | 0 key, 1 divider code, 2 reload value, 3 unused |
| bus_wdata | input | 16 | Write data |
| pr_busy | output | 1 | Divider update still crossing into wd_clk |
| rl_busy | output | 1 | Reload update still crossing into wd_clk |
| wd_reset_req | output | 1 | Sticky system reset request |

## Verification
A busy flag is due one bus-clock edge after the write. The bench samples it on the bus-clock falling edge that ends the write, and checks it again a fixed number of slow cycles later. A key or setting takes effect about three slow-clock edges after it is launched, and the exact edge depends on the phase between the two clocks. For that reason each timeout is counted in slow-clock rising edges from the end of the write and accepted in a window of expected+2 to expected+6. Every vector spaces its expected count far enough apart from its neighbours that a wrong divisor or reload count lands outside the window. Checks of ignored writes read the busy flag in the following bus cycle, and confirm that the timeout is unchanged.

// File: rtl/lsw_pkg.sv
package lsw_pkg;
    localparam int KEY_W = 16;
    localparam logic [KEY_W-1:0] KEY_ARM  = 16'hCCCC;
    localparam logic [KEY_W-1:0] KEY_FEED = 16'hAAAA;
    localparam logic [KEY_W-1:0] KEY_OPEN = 16'h5555;

    localparam logic [1:0] ADDR_KEY  = 2'd0;
    localparam logic [1:0] ADDR_DIV  = 2'd1;
    localparam logic [1:0] ADDR_LOAD = 2'd2;

    // key channel payload bit positions
    localparam int EV_ARM  = 0;
    localparam int EV_FEED = 1;
    localparam int EV_W    = 2;
endpackage

// File: rtl/lsw_xfer.sv
// Lossless command channel from clock a to clock b (toggle request, toggle ack).
module lsw_xfer #(
    parameter int W     = 8,
    parameter bit ACCUM = 1'b0   // 1: OR new writes into a pending payload
) (
    input  logic         clk_a,
    input  logic         clk_b,
    input  logic         rst_n,
    input  logic         wr_a,
    input  logic [W-1:0] wdata_a,
    output logic         busy_a,
    output logic         vld_b,
    output logic [W-1:0] data_b
);
    typedef struct packed {
        logic [W-1:0] shadow;
        logic         pend;
        logic [W-1:0] hold;
        logic         req_tgl;
        logic         ack_s1;
        logic         ack_s2;
    } a_s;

    typedef struct packed {
        logic req_s1;
        logic req_s2;
        logic req_s3;
    } b_s;

    a_s a_d, a_q;
    b_s b_d, b_q;
    logic inflight, launch;

    always_comb begin
        a_d      = a_q;
        inflight = (a_q.req_tgl != a_q.ack_s2);
        launch   = a_q.pend && !inflight;
        a_d.ack_s1 = b_q.req_s3;
        a_d.ack_s2 = a_q.ack_s1;
        if (launch) begin
            a_d.hold    = a_q.shadow;
            a_d.req_tgl = ~a_q.req_tgl;
            a_d.pend    = 1'b0;
        end
        if (wr_a) begin
            a_d.pend = 1'b1;
            if (ACCUM && a_q.pend && !launch) begin
                a_d.shadow = a_q.shadow | wdata_a;
            end else begin
                a_d.shadow = wdata_a;
            end
        end
    end

    always_ff @(posedge clk_a or negedge rst_n) begin
        if (!rst_n) begin
            a_q <= '0;
        end else begin
            a_q <= a_d;
        end
    end

    always_comb begin
        b_d        = b_q;
        b_d.req_s1 = a_q.req_tgl;
        b_d.req_s2 = b_q.req_s1;
        b_d.req_s3 = b_q.req_s2;
    end

    always_ff @(posedge clk_b or negedge rst_n) begin
        if (!rst_n) begin
            b_q <= '0;
        end else begin
            b_q <= b_d;
        end
    end

    assign busy_a = a_q.pend | inflight;
    assign vld_b  = b_q.req_s2 ^ b_q.req_s3;
    assign data_b = a_q.hold;

    AST_BUSY_ON_WRITE: assert property (@(posedge clk_a) disable iff (!rst_n)
        wr_a |=> busy_a);                                   // R9
    AST_SINGLE_APPLY: assert property (@(posedge clk_b) disable iff (!rst_n)
        vld_b |=> !vld_b);                                  // R10
endmodule

// File: rtl/lsw_core.sv
// Slow-clock side: prescaler, down-counter, arming and expiry.
module lsw_core #(
    parameter int PR_W    = 3,
    parameter int RL_W    = 12,
    parameter int LOG_MIN = 2,
    parameter int LOG_MAX = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            arm_i,
    input  logic            feed_i,
    input  logic            div_vld,
    input  logic [PR_W-1:0] div_code,
    input  logic            load_vld,
    input  logic [RL_W-1:0] load_val,
    output logic            req_o
);
    localparam int SAT  = LOG_MAX - LOG_MIN;
    localparam int PC_W = LOG_MAX;

    typedef struct packed {
        logic            armed;
        logic            expired;
        logic [PR_W-1:0] code;
        logic [RL_W-1:0] reload;
        logic [PC_W-1:0] pcnt;
        logic [RL_W-1:0] cnt;
    } core_s;

    core_s d, q;
    logic [PC_W-1:0] lim;
    logic tick, restart;

    function automatic logic [PC_W-1:0] lim_of(input logic [PR_W-1:0] c);
        logic [PC_W:0] full;
        int sh;
        sh   = (int'(c) > SAT) ? SAT : int'(c);
        full = ((PC_W+1)'(1) << (LOG_MIN + sh)) - (PC_W+1)'(1);
        return full[PC_W-1:0];
    endfunction

    always_comb begin
        d       = q;
        lim     = lim_of(q.code);
        tick    = q.armed && !q.expired && (q.pcnt == lim);
        restart = (arm_i || (feed_i && q.armed)) && !q.expired;

        if (q.armed && !q.expired) begin
            d.pcnt = tick ? '0 : q.pcnt + 1'b1;
        end
        if (tick && !restart) begin
            if (q.cnt <= RL_W'(1)) begin
                d.expired = 1'b1;
                d.cnt     = '0;
            end else begin
                d.cnt = q.cnt - 1'b1;
            end
        end
        if (div_vld) begin
            d.code = div_code;
            d.pcnt = '0;
        end
        if (load_vld) begin
            d.reload = load_val;
        end
        if (restart) begin
            d.armed = 1'b1;
            d.cnt   = q.reload;
            d.pcnt  = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q        <= '0;
            q.reload <= '1;
        end else begin
            q <= d;
        end
    end

    assign req_o = q.expired;

    AST_STAY_ARMED: assert property (@(posedge clk) disable iff (!rst_n)
        q.armed |=> q.armed);                               // R8
    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        req_o |=> req_o);                                   // R3
    AST_REQ_NEEDS_ARM: assert property (@(posedge clk) disable iff (!rst_n)
        req_o |-> q.armed);                                 // R2
    AST_PCNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        q.pcnt <= lim);                                     // R4
endmodule

// File: rtl/lsw_watchdog.sv
// Top: bus key decode, write lock, three crossing channels, slow-clock core.
module lsw_watchdog #(
    parameter int PR_W   = 3,
    parameter int RL_W   = 12,
    parameter int DATA_W = 16
) (
    input  logic              bus_clk,
    input  logic              wd_clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [1:0]        bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic              pr_busy,
    output logic              rl_busy,
    output logic              wd_reset_req
);
    import lsw_pkg::*;

    typedef struct packed {
        logic open;
    } bus_s;

    bus_s bd, bq;
    logic key_wr, div_wr, load_wr, ev_wr, key_busy;
    logic [EV_W-1:0] ev_data, ev_out;
    logic ev_vld, div_vld, load_vld;
    logic [PR_W-1:0] div_out;
    logic [RL_W-1:0] load_out;

    always_comb begin
        bd      = bq;
        key_wr  = bus_wr && (bus_addr == ADDR_KEY);
        div_wr  = bus_wr && (bus_addr == ADDR_DIV)  && bq.open;
        load_wr = bus_wr && (bus_addr == ADDR_LOAD) && bq.open;
        ev_data = '0;
        ev_data[EV_ARM]  = (bus_wdata == KEY_ARM);
        ev_data[EV_FEED] = (bus_wdata == KEY_FEED);
        ev_wr   = key_wr && (ev_data != '0);
        if (key_wr) begin
            bd.open = (bus_wdata == KEY_OPEN);
        end
    end

    always_ff @(posedge bus_clk or negedge rst_n) begin
        if (!rst_n) begin
            bq <= '0;
        end else begin
            bq <= bd;
        end
    end

    lsw_xfer #(.W(EV_W), .ACCUM(1'b1)) u_key_ch (
        .clk_a(bus_clk), .clk_b(wd_clk), .rst_n(rst_n),
        .wr_a(ev_wr), .wdata_a(ev_data), .busy_a(key_busy),
        .vld_b(ev_vld), .data_b(ev_out)
    );

    lsw_xfer #(.W(PR_W), .ACCUM(1'b0)) u_div_ch (
        .clk_a(bus_clk), .clk_b(wd_clk), .rst_n(rst_n),
        .wr_a(div_wr), .wdata_a(bus_wdata[PR_W-1:0]), .busy_a(pr_busy),
        .vld_b(div_vld), .data_b(div_out)
    );

    lsw_xfer #(.W(RL_W), .ACCUM(1'b0)) u_load_ch (
        .clk_a(bus_clk), .clk_b(wd_clk), .rst_n(rst_n),
        .wr_a(load_wr), .wdata_a(bus_wdata[RL_W-1:0]), .busy_a(rl_busy),
        .vld_b(load_vld), .data_b(load_out)
    );

    lsw_core #(.PR_W(PR_W), .RL_W(RL_W)) u_core (
        .clk(wd_clk), .rst_n(rst_n),
        .arm_i(ev_vld && ev_out[EV_ARM]),
        .feed_i(ev_vld && ev_out[EV_FEED]),
        .div_vld(div_vld), .div_code(div_out),
        .load_vld(load_vld), .load_val(load_out),
        .req_o(wd_reset_req)
    );

    AST_LOCKED_DIV: assert property (@(posedge bus_clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_DIV && !bq.open && !pr_busy) |=> !pr_busy);   // R7
    AST_LOCKED_LOAD: assert property (@(posedge bus_clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_LOAD && !bq.open && !rl_busy) |=> !rl_busy);  // R7
    AST_KEY_PENDING: assert property (@(posedge bus_clk) disable iff (!rst_n)
        (key_wr && bus_wdata == KEY_ARM) |=> key_busy);                           // R10
endmodule

// File: tb/lsw_watchdog_tb_top.sv
module lsw_watchdog_tb_top;
    logic bus_clk = 1'b0;
    logic wd_clk  = 1'b0;
    logic rst_n   = 1'b0;
    logic bus_wr  = 1'b0;
    logic [1:0]  bus_addr  = '0;
    logic [15:0] bus_wdata = '0;
    logic pr_busy, rl_busy, wd_reset_req;

    int n_chk  = 0;
    int n_fail = 0;

    always #2  bus_clk = ~bus_clk;   // 250 MHz
    always #10 wd_clk  = ~wd_clk;

    lsw_watchdog dut_i (
        .bus_clk(bus_clk), .wd_clk(wd_clk), .rst_n(rst_n),
        .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .pr_busy(pr_busy), .rl_busy(rl_busy), .wd_reset_req(wd_reset_req)
    );

    // {divider code, reload, expected slow cycles}
    localparam logic [30:0] VEC [10] = '{
        {3'd0, 12'd5,  16'd20},
        {3'd1, 12'd3,  16'd24},
        {3'd2, 12'd2,  16'd32},
        {3'd3, 12'd1,  16'd32},
        {3'd4, 12'd0,  16'd64},
        {3'd5, 12'd1,  16'd128},
        {3'd6, 12'd1,  16'd256},
        {3'd7, 12'd2,  16'd512},
        {3'd0, 12'd12, 16'd48},
        {3'd2, 12'd7,  16'd112}
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(posedge wd_clk);
        @(negedge bus_clk);
        rst_n = 1'b1;
        @(negedge bus_clk);
    endtask

    task automatic bwrite(input logic [1:0] a, input logic [15:0] v);
        @(negedge bus_clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = v;
        @(negedge bus_clk);
        bus_wr = 1'b0;
    endtask

    task automatic wait_wd(input int n);
        repeat (n) @(posedge wd_clk);
        @(negedge wd_clk);
    endtask

    task automatic wait_idle();
        for (int k = 0; k < 100 && (pr_busy || rl_busy); k++) @(negedge bus_clk);
    endtask

    task automatic measure(input int limit, output int cyc);
        cyc = 0;
        while (!wd_reset_req && cyc < limit) begin
            @(posedge wd_clk);
            cyc++;
            @(negedge wd_clk);
        end
    endtask

    task automatic check_window(input string req, input int got, input int exp);
        check((got >= exp + 2) && (got <= exp + 6) && wd_reset_req, req, got, exp + 3);
    endtask

    initial begin
        int got;
        fork
            begin
                repeat (190000) @(posedge bus_clk);
                n_chk++;
                n_fail++;
                $display("FAIL watchdog: actual timeout expected completion");
                $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
                $finish;
            end
        join_none

        // R1: reset state
        do_reset();
        check(!wd_reset_req && !pr_busy && !rl_busy, "R1 reset outputs",
              {wd_reset_req, pr_busy, rl_busy}, 0);

        // Vector table: R3 R4 R5
        for (int i = 0; i < 10; i++) begin
            do_reset();
            bwrite(2'd0, 16'h5555);
            bwrite(2'd1, {13'd0, VEC[i][30:28]});
            bwrite(2'd2, {4'd0, VEC[i][27:16]});
            wait_idle();
            bwrite(2'd0, 16'hCCCC);
            measure(int'(VEC[i][15:0]) + 40, got);
            check_window("R3/R4/R5 timeout vector", got, int'(VEC[i][15:0]));
        end

        // R3: request stays high
        wait_wd(40);
        check(wd_reset_req == 1'b1, "R3 sticky request", wd_reset_req, 1);

        // R2: no arming, feed before arm ignored
        do_reset();
        bwrite(2'd0, 16'h5555);
        bwrite(2'd2, 16'd2);
        wait_idle();
        bwrite(2'd0, 16'hAAAA);
        wait_wd(200);
        check(wd_reset_req == 1'b0, "R2 idle until armed", wd_reset_req, 0);

        // R9: busy rises and clears
        do_reset();
        bwrite(2'd0, 16'h5555);
        bwrite(2'd2, 16'd9);
        check(rl_busy == 1'b1, "R9 rl_busy after write", rl_busy, 1);
        bwrite(2'd1, 16'd1);
        check(pr_busy == 1'b1, "R9 pr_busy after write", pr_busy, 1);
        wait_wd(10);
        check(!rl_busy && !pr_busy, "R9 busy clears", {pr_busy, rl_busy}, 0);

        // R7: closed access ignored
        do_reset();
        bwrite(2'd0, 16'h5555);
        bwrite(2'd2, 16'd4);
        wait_idle();
        bwrite(2'd0, 16'h1234);
        bwrite(2'd2, 16'd100);
        check(rl_busy == 1'b0, "R7 locked reload no busy", rl_busy, 0);
        bwrite(2'd1, 16'd3);
        check(pr_busy == 1'b0, "R7 locked divider no busy", pr_busy, 0);
        wait_wd(10);
        bwrite(2'd0, 16'hCCCC);
        measure(80, got);
        check_window("R7 settings unchanged", got, 16);

        // R10: last setting wins, key events not lost
        do_reset();
        bwrite(2'd0, 16'h5555);
        bwrite(2'd2, 16'd3);
        bwrite(2'd2, 16'd6);
        wait_idle();
        bwrite(2'd0, 16'hCCCC);
        measure(80, got);
        check_window("R10 last reload applied", got, 24);

        do_reset();
        bwrite(2'd0, 16'h5555);
        bwrite(2'd2, 16'd4);
        wait_idle();
        bwrite(2'd0, 16'hAAAA);
        bwrite(2'd0, 16'hCCCC);
        measure(80, got);
        check_window("R10 arm behind feed kept", got, 16);

        // R6: feeding holds off expiry
        do_reset();
        bwrite(2'd0, 16'h5555);
        bwrite(2'd2, 16'd8);
        wait_idle();
        bwrite(2'd0, 16'hCCCC);
        for (int f = 0; f < 5; f++) begin
            wait_wd(20);
            bwrite(2'd0, 16'hAAAA);
        end
        check(wd_reset_req == 1'b0, "R6 fed no request", wd_reset_req, 0);
        measure(100, got);
        check_window("R6 expiry after last feed", got, 32);

        // R8: writes cannot stop it; only reset
        do_reset();
        bwrite(2'd0, 16'h5555);
        bwrite(2'd2, 16'd10);
        wait_idle();
        bwrite(2'd0, 16'hCCCC);
        wait_wd(5);
        bwrite(2'd0, 16'h0000);
        bwrite(2'd0, 16'h5555);
        bwrite(2'd2, 16'd4000);
        bwrite(2'd0, 16'hFFFF);
        measure(80, got);
        check(wd_reset_req == 1'b1, "R8 expiry despite writes", wd_reset_req, 1);
        do_reset();
        wait_wd(100);
        check(wd_reset_req == 1'b0, "R8 reset returns to idle", wd_reset_req, 0);

        // R1: defaults give 4 x 4095
        do_reset();
        bwrite(2'd0, 16'hCCCC);
        measure(16450, got);
        check_window("R1 default timeout", got, 16380);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule